// File: doc/BRIEF.md
# Temperature Event Threshold Comparator

This block watches a stream of signed temperature samples and drives an active-low event line when a sample leaves a programmed window or passes a critical trip point. Three limits are held on inputs: an upper bound, a lower bound and a critical bound. Each limit has its own out-of-range flag with programmable hysteresis, so a flag that has tripped only releases once the temperature has moved back past the limit by the hysteresis amount.

Three output modes are supported. In compare mode the output simply follows the flags. In interrupt mode a new window excursion sets a sticky latch that only a software clear pulse releases. In critical-only mode the window is ignored and only the critical flag drives the output. In every mode a critical condition behaves like a comparator and cannot be cleared by software. A global enable forces the output inactive.

Temperatures and limits are 11-bit two's-complement numbers in quarter-degree steps. A limit flag only changes on a cycle where a sample is marked valid.

Top module: `temp_evt_cmp`

## Requirements
- R1: While reset is asserted and after its release, before any sample, `evt_no` is high (inactive).
- R2: On a valid sample, the upper flag trips when the temperature is strictly greater than `upper_lim_i` and the lower flag trips when it is strictly less than `lower_lim_i`; in compare mode (`mode_i`=1) `evt_no` goes low in the cycle after that sample.
- R3: A tripped upper or critical flag releases on a valid sample at or below the limit minus the hysteresis; `hyst_sel_i` codes 0, 1, 2, 3 select 0, 6, 12, 24 LSB (0, 1.5, 3, 6 degrees).
- R4: A tripped lower flag releases on a valid sample at or above the lower limit plus the hysteresis.
- R5: In interrupt mode (`mode_i`=0) a sample that takes the window from inside to outside sets a latch; `evt_no` stays low after the temperature returns inside until `clr_i` is pulsed.
- R6: In compare mode `clr_i` has no effect on `evt_no`.
- R7: In critical-only mode (`mode_i`=2) `evt_no` goes low only while the critical flag (temperature above `crit_lim_i`, with hysteresis) is set; window flags are ignored.
- R8: A set critical flag holds `evt_no` low in interrupt and compare modes as well, and `clr_i` does not release it.
- R9: Temperature changes without `temp_vld_i` have no effect on the flags or `evt_no`.
- R10: With `evt_en_i` low, `evt_no` is high and the interrupt latch is held clear; limit flags keep tracking samples.
- R11: When `clr_i` and a sample that newly crosses the window fall in the same cycle in interrupt mode, the latch is set.
- R12: `mode_i`=3 behaves as compare mode; leaving interrupt mode clears the latch.
- R13: Comparisons are signed: negative temperatures and negative limits compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_i | input | 11 | Signed temperature sample, 0.25 degree LSB |
| temp_vld_i | input | 1 | Sample valid strobe |
| upper_lim_i | input | 11 | Signed upper window limit |
| lower_lim_i | input | 11 | Signed lower window limit |
| crit_lim_i | input | 11 | Signed critical limit |
| hyst_sel_i | input | 2 | Hysteresis code |
| mode_i | input | 2 | 0 interrupt, 1 compare, 2 critical-only, 3 compare |
| evt_en_i | input | 1 | Event enable |
| clr_i | input | 1 | Software clear pulse for the interrupt latch |
| evt_no | output | 1 | Active-low event output |

## Verification
The two functions that collide are the software clear and the latch set from a fresh window crossing: the bench first parks the temperature inside the window, then presents a crossing sample and a clear pulse in the same cycle and expects the output to stay low afterwards. A second collision puts a clear on a cycle where the critical flag is held, and the output must stay low until a valid sample releases the critical flag through its hysteresis. A behavioural model built from integer arithmetic predicts the output every cycle, so each ordering is judged cycle by cycle, not only at the end of a phase.

// File: rtl/temp_evt_pkg.sv
package temp_evt_pkg;
  localparam int unsigned HYST_CODE_W = 2;
  localparam int unsigned HYST_OFS_W  = 5;
  localparam int unsigned NUM_LIM     = 3;
  localparam int unsigned LIM_UPPER   = 0;
  localparam int unsigned LIM_LOWER   = 1;
  localparam int unsigned LIM_CRIT    = 2;

  typedef enum logic [1:0] {
    EVT_INTR    = 2'd0,
    EVT_CMP     = 2'd1,
    EVT_CRIT    = 2'd2,
    EVT_CMP_ALT = 2'd3
  } evt_mode_e;

  // 1.5 deg = 6 quarter steps, doubling per code
  function automatic logic [HYST_OFS_W-1:0] hyst_ofs(input logic [HYST_CODE_W-1:0] code);
    logic [HYST_OFS_W-1:0] base;
    base = HYST_OFS_W'(6);
    if (code == '0) return '0;
    return base << (code - 1'b1);
  endfunction
endpackage

// File: rtl/temp_lim_track.sv
module temp_lim_track #(
  parameter int unsigned W         = 11,
  parameter int unsigned OFS_W     = 5,
  parameter bit          TRIP_HIGH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [W-1:0]     temp_i,
  input  logic [W-1:0]     lim_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             flag_o,
  output logic             flag_nxt_o
);
  localparam int unsigned XW = W + 2;

  logic signed [XW-1:0] t_x, l_x, h_x;
  logic trip, rel, flag_q;

  assign t_x = {{2{temp_i[W-1]}}, temp_i};
  assign l_x = {{2{lim_i[W-1]}}, lim_i};
  assign h_x = {{(XW-OFS_W){1'b0}}, ofs_i};

  generate
    if (TRIP_HIGH) begin : g_high
      assign trip = t_x > l_x;
      assign rel  = t_x <= (l_x - h_x);
    end else begin : g_low
      assign trip = t_x < l_x;
      assign rel  = t_x >= (l_x + h_x);
    end
  endgenerate

  always_comb begin
    flag_nxt_o = flag_q;
    if (smp_vld_i) flag_nxt_o = flag_q ? ~rel : trip;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/temp_evt_ctrl.sv
module temp_evt_ctrl
  import temp_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      smp_vld_i,
  input  logic      win_i,
  input  logic      win_nxt_i,
  input  logic      crit_i,
  input  evt_mode_e mode_i,
  input  logic      en_i,
  input  logic      clr_i,
  output logic      evt_no
);
  logic lat_q, win_rise, act;

  assign win_rise = smp_vld_i & win_nxt_i & ~win_i;

  // set beats clear when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lat_q <= 1'b0;
    else if (!en_i || mode_i != EVT_INTR) lat_q <= 1'b0;
    else if (win_rise)                    lat_q <= 1'b1;
    else if (clr_i)                       lat_q <= 1'b0;
  end

  always_comb begin
    unique case (mode_i)
      EVT_INTR: act = lat_q | crit_i;
      EVT_CRIT: act = crit_i;
      default:  act = win_i | crit_i;
    endcase
  end

  assign evt_no = ~(en_i & act);
endmodule

// File: rtl/temp_evt_cmp.sv
module temp_evt_cmp
  import temp_evt_pkg::*;
#(
  parameter int unsigned TEMP_W = 11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TEMP_W-1:0]      temp_i,
  input  logic                   temp_vld_i,
  input  logic [TEMP_W-1:0]      upper_lim_i,
  input  logic [TEMP_W-1:0]      lower_lim_i,
  input  logic [TEMP_W-1:0]      crit_lim_i,
  input  logic [HYST_CODE_W-1:0] hyst_sel_i,
  input  logic [1:0]             mode_i,
  input  logic                   evt_en_i,
  input  logic                   clr_i,
  output logic                   evt_no
);
  logic [NUM_LIM-1:0][TEMP_W-1:0] lims;
  logic [NUM_LIM-1:0]             flag_q, flag_d;
  logic [HYST_OFS_W-1:0]          ofs;

  assign lims[LIM_UPPER] = upper_lim_i;
  assign lims[LIM_LOWER] = lower_lim_i;
  assign lims[LIM_CRIT]  = crit_lim_i;
  assign ofs             = hyst_ofs(hyst_sel_i);

  for (genvar i = 0; i < NUM_LIM; i++) begin : g_trk
    temp_lim_track #(
      .W        (TEMP_W),
      .OFS_W    (HYST_OFS_W),
      .TRIP_HIGH(i != LIM_LOWER)
    ) u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_vld_i (temp_vld_i),
      .temp_i    (temp_i),
      .lim_i     (lims[i]),
      .ofs_i     (ofs),
      .flag_o    (flag_q[i]),
      .flag_nxt_o(flag_d[i])
    );
  end

  temp_evt_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_vld_i(temp_vld_i),
    .win_i    (flag_q[LIM_UPPER] | flag_q[LIM_LOWER]),
    .win_nxt_i(flag_d[LIM_UPPER] | flag_d[LIM_LOWER]),
    .crit_i   (flag_q[LIM_CRIT]),
    .mode_i   (evt_mode_e'(mode_i)),
    .en_i     (evt_en_i),
    .clr_i    (clr_i),
    .evt_no   (evt_no)
  );
endmodule

// File: rtl/temp_evt_cmp_chk.sv
module temp_evt_cmp_chk #(
  parameter int unsigned TEMP_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic              temp_vld_i,
  input logic [TEMP_W-1:0] crit_lim_i,
  input logic [1:0]        mode_i,
  input logic              evt_en_i,
  input logic              clr_i,
  input logic              evt_no
);
  a_r10_disabled_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_en_i |-> evt_no);

  a_r9_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!temp_vld_i && !clr_i) ##1 ($stable(mode_i) && $stable(evt_en_i)) |-> $stable(evt_no));

  a_r6_cmp_clear_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && evt_en_i && !evt_no && clr_i && !temp_vld_i)
      ##1 (mode_i == 2'd1 && evt_en_i) |-> !evt_no);

  a_r5_intr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && evt_en_i && !evt_no && !clr_i && !temp_vld_i)
      ##1 (mode_i == 2'd0 && evt_en_i) |-> !evt_no);

  a_r7_crit_needs_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && evt_en_i && $past(mode_i) == 2'd2 && $past(evt_en_i) && $fell(evt_no))
      |-> ($past(temp_vld_i) && $signed($past(temp_i)) > $signed($past(crit_lim_i))));
endmodule

bind temp_evt_cmp temp_evt_cmp_chk #(.TEMP_W(TEMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .temp_i    (temp_i),
  .temp_vld_i(temp_vld_i),
  .crit_lim_i(crit_lim_i),
  .mode_i    (mode_i),
  .evt_en_i  (evt_en_i),
  .clr_i     (clr_i),
  .evt_no    (evt_no)
);

// File: tb/temp_evt_cmp_test.sv
`timescale 1ns/1ps
module temp_evt_cmp_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] temp, up_lim, lo_lim, cr_lim;
  logic        vld, en, clr;
  logic [1:0]  hyst, mode;
  logic        evt_n;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  bit m_up, m_lo, m_cr, m_lat;
  bit n_up, n_lo, n_cr;
  int t_i, h_i;

  always #5 clk = ~clk;

  temp_evt_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .temp_i(temp), .temp_vld_i(vld),
    .upper_lim_i(up_lim), .lower_lim_i(lo_lim), .crit_lim_i(cr_lim),
    .hyst_sel_i(hyst), .mode_i(mode), .evt_en_i(en), .clr_i(clr), .evt_no(evt_n)
  );

  function automatic int sx(logic [10:0] v);
    return int'($signed(v));
  endfunction

  function automatic int hofs(logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 6;
      2'd2: return 12;
      default: return 24;
    endcase
  endfunction

  function automatic bit model_evt_n();
    bit act;
    if (mode == 2'd0)      act = m_lat | m_cr;
    else if (mode == 2'd2) act = m_cr;
    else                   act = m_up | m_lo | m_cr;
    return !(en && act);
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_lo = 0; m_cr = 0; m_lat = 0;
    end else begin
      t_i = sx(temp);
      h_i = hofs(hyst);
      n_up = m_up; n_lo = m_lo; n_cr = m_cr;
      if (vld) begin
        n_up = m_up ? !(t_i <= sx(up_lim) - h_i) : (t_i > sx(up_lim));
        n_lo = m_lo ? !(t_i >= sx(lo_lim) + h_i) : (t_i < sx(lo_lim));
        n_cr = m_cr ? !(t_i <= sx(cr_lim) - h_i) : (t_i > sx(cr_lim));
      end
      if (!en || mode != 2'd0)                     m_lat = 0;
      else if (vld && (n_up || n_lo) && !(m_up || m_lo)) m_lat = 1;
      else if (clr)                                m_lat = 0;
      m_up = n_up; m_lo = n_lo; m_cr = n_cr;
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #3;
    n_cmp++;
    if (evt_n !== model_evt_n()) begin
      n_bad++;
      $display("FAIL %s cycle compare: evt_no=%0b expected %0b", cur_req, evt_n, model_evt_n());
    end
  end

  task automatic expect_evt(input bit e, input string r);
    n_cmp++;
    if (evt_n !== e) begin
      n_bad++;
      $display("FAIL %s directed: evt_no=%0b expected %0b", r, evt_n, e);
    end
  endtask

  task automatic smp(input int t, input bit c = 1'b0);
    @(negedge clk);
    temp = 11'(t); vld = 1'b1; clr = c;
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: cycles=20000 expected fewer");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; temp = '0; vld = 0; clr = 0; en = 1; mode = 2'd1; hyst = 2'd0;
    up_lim = 11'd320; lo_lim = 11'd40; cr_lim = 11'd380;
    idle(3);
    cur_req = "R1"; expect_evt(1'b1, "R1");
    rst_n = 1'b1;
    idle(2); expect_evt(1'b1, "R1");

    cur_req = "R2";
    smp(300); expect_evt(1'b1, "R2");
    smp(320); expect_evt(1'b1, "R2");
    smp(321); expect_evt(1'b0, "R2");
    smp(320); expect_evt(1'b1, "R2");
    smp(39);  expect_evt(1'b0, "R2");
    smp(40);  expect_evt(1'b1, "R2");

    cur_req = "R3";
    hyst = 2'd1; smp(330); smp(315); expect_evt(1'b0, "R3");
    smp(314); expect_evt(1'b1, "R3");
    hyst = 2'd2; smp(330); smp(309); expect_evt(1'b0, "R3");
    smp(308); expect_evt(1'b1, "R3");
    hyst = 2'd3; smp(330); smp(297); expect_evt(1'b0, "R3");
    smp(296); expect_evt(1'b1, "R3");

    cur_req = "R4";
    hyst = 2'd2; smp(30); smp(51); expect_evt(1'b0, "R4");
    smp(52); expect_evt(1'b1, "R4");

    cur_req = "R13";
    hyst = 2'd0; lo_lim = 11'h7B0;
    smp(-81); expect_evt(1'b0, "R13");
    smp(-80); expect_evt(1'b1, "R13");
    smp(-1000); expect_evt(1'b0, "R13");
    smp(0); expect_evt(1'b1, "R13");
    lo_lim = 11'd40;

    cur_req = "R9";
    smp(100);
    @(negedge clk); temp = 11'd500; idle(4); expect_evt(1'b1, "R9");
    smp(330);
    @(negedge clk); temp = 11'd100; idle(4); expect_evt(1'b0, "R9");

    cur_req = "R6";
    pulse_clr(); idle(1); expect_evt(1'b0, "R6");
    smp(100); expect_evt(1'b1, "R6");

    cur_req = "R5";
    mode = 2'd0; idle(1);
    smp(330); expect_evt(1'b0, "R5");
    smp(100); idle(3); expect_evt(1'b0, "R5");
    pulse_clr(); expect_evt(1'b1, "R5");

    cur_req = "R11";
    smp(200, 1'b1); expect_evt(1'b1, "R11");
    smp(330, 1'b1); expect_evt(1'b0, "R11");
    smp(100); pulse_clr(); expect_evt(1'b1, "R11");

    cur_req = "R8";
    smp(390); expect_evt(1'b0, "R8");
    pulse_clr(); idle(2); expect_evt(1'b0, "R8");
    smp(300); expect_evt(1'b1, "R8");
    mode = 2'd1; smp(390); pulse_clr(); expect_evt(1'b0, "R8");
    smp(100); expect_evt(1'b1, "R8");

    cur_req = "R7";
    mode = 2'd2;
    smp(330); expect_evt(1'b1, "R7");
    smp(10);  expect_evt(1'b1, "R7");
    smp(381); expect_evt(1'b0, "R7");
    pulse_clr(); expect_evt(1'b0, "R7");
    smp(370); expect_evt(1'b1, "R7");

    cur_req = "R10";
    mode = 2'd1; en = 1'b0;
    smp(390); expect_evt(1'b1, "R10");
    @(negedge clk); en = 1'b1; #1 expect_evt(1'b0, "R10");
    smp(100);
    mode = 2'd0; smp(330); expect_evt(1'b0, "R10");
    @(negedge clk); en = 1'b0; #1 expect_evt(1'b1, "R10");
    @(negedge clk); en = 1'b1; #1 expect_evt(1'b1, "R10");

    cur_req = "R12";
    smp(100); smp(330); expect_evt(1'b0, "R12");
    @(negedge clk); mode = 2'd3;
    smp(100); expect_evt(1'b1, "R12");
    smp(330); pulse_clr(); expect_evt(1'b0, "R12");
    @(negedge clk); mode = 2'd0; idle(1); expect_evt(1'b1, "R12");
    smp(100);

    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule